// File: doc/BRIEF.md
# SPI Bit-Rate Clock Generator

This block derives all serial-clock timing for an SPI port from one fast reference clock. The nominal reference is 300 MHz. In master mode an integer divisor N sets the bit period to N reference cycles. The block drives the serial clock and two single-cycle strobes that tell a neighbouring shift register when to sample and when to shift. Software rounds the divisor up from reference/rate, so the real rate never exceeds the request. For example, a divisor of 22 gives about 13.64 Mbps, 9 gives about 33 Mbps, 15 gives 20 Mbps and 600 gives 500 kbps. Odd divisors are fully supported.

In slave mode the same block stops driving the clock and instead oversamples an external serial clock at the reference rate. The external clock passes through a two-flop synchronizer. The block emits the same sample and shift strobes on the recovered rising and falling edges. The slave rate is set wholly by the external master. Its nominal setting is a fixed divisor of 6, which means the external clock must hold each level for at least 3 reference cycles. The divisor input is ignored in slave mode.

The clock idles low (SPI mode 0). Sampling happens on the rising edge and shifting on the falling edge.

Top module: `spi_rate_gen`

## Requirements
- R1: While reset is asserted, or after a clock edge with `en_i` low, `sck_o` is 0. While `en_i` is low, `sample_o` and `shift_o` never pulse.
- R2: In master mode with a stable divisor, consecutive rising edges of `sck_o` are exactly N reference cycles apart, where N = max(`divisor_i`, 2). All 12 divisor bits are used (N up to 4095).
- R3: In master mode, `sck_o` is high for floor(N/2) cycles and low for ceil(N/2) cycles in each period.
- R4: In master mode, `sample_o` is 1 for exactly the first cycle in which `sck_o` reads 1, and at no other time.
- R5: In master mode, `shift_o` is 1 for exactly the first cycle in which `sck_o` reads 0 after a high phase, while enabled.
- R6: A divisor of 0 or 1 behaves exactly like a divisor of 2.
- R7: With `slave_mode_i` = 1, `sck_o` is 0 from the next edge on, and the value of `divisor_i` has no effect on any output.
- R8: In slave mode with `en_i` = 1, a rising transition of `ext_sck_i` produces one `sample_o` pulse and a falling transition produces one `shift_o` pulse. Each pulse is visible in the cycle after the second reference edge following the change and lasts one cycle.
- R9: Dropping `en_i` in master mode while `sck_o` is high forces `sck_o` to 0 at the next edge without a `shift_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables clock generation or edge recovery |
| slave_mode_i | input | 1 | 0 = master (drive clock), 1 = slave (recover external clock) |
| divisor_i | input | 12 | Bit period in reference cycles (master mode) |
| ext_sck_i | input | 1 | External serial clock, used in slave mode |
| sck_o | output | 1 | Serial clock in master mode, 0 otherwise |
| sample_o | output | 1 | One-cycle strobe on the serial-clock rising edge |
| shift_o | output | 1 | One-cycle strobe on the serial-clock falling edge |

## Verification
The high-time assertion assumes `divisor_i` changes only while the generator is disabled. The stimulus therefore sets each divisor before raising `en_i` and drops `en_i` before loading the next one. The slave-side check assumes the external clock holds each level for at least half the fixed slave divisor, which is 3 reference cycles. The bench toggles `ext_sck_i` no faster than once every 3 cycles. The mode-0 strobe checks assume `slave_mode_i` does not change while enabled, so every mode switch in the stimulus happens with `en_i` low.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int unsigned DIV_W       = 12;
  localparam int unsigned SLAVE_DIV   = 6;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned MIN_DIV     = 2;

  typedef struct packed {
    logic sck;
    logic sample;
    logic shift;
  } spi_tick_t;
endpackage

// File: rtl/spi_master_div.sv
module spi_master_div
  import spi_rate_pkg::*;
#(
  parameter int unsigned DW   = DIV_W,
  parameter int unsigned MINV = MIN_DIV
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] divisor_i,
  output spi_tick_t     tick_o
);
  localparam logic [DW-1:0] MinDiv = DW'(MINV);

  logic [DW-1:0] n_eff, lo_len, cnt_q, cnt_nxt, hi_len_q;
  spi_tick_t     tick_q;

  // clamp small divisors; low phase takes the odd cycle
  assign n_eff   = (divisor_i < MinDiv) ? MinDiv : divisor_i;
  assign lo_len  = n_eff - (n_eff >> 1);
  assign cnt_nxt = (cnt_q >= n_eff - DW'(1)) ? '0 : cnt_q + DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tick_q <= '0;
    end else begin
      cnt_q         <= cnt_nxt;
      tick_q.sck    <= (cnt_nxt >= lo_len);
      tick_q.sample <= (cnt_nxt == lo_len);
      tick_q.shift  <= (cnt_nxt == '0) && tick_q.sck;
    end
  end

  assign tick_o = tick_q;

  // checker state: length of the current high phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_len_q <= '0;
    else if (tick_q.sck) hi_len_q <= hi_len_q + DW'(1);
    else                 hi_len_q <= '0;
  end

  a_r4_sample_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q.sample |-> tick_q.sck && !$past(tick_q.sck));
  a_r5_shift_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q.shift |-> !tick_q.sck && $past(tick_q.sck));
  a_r3_high_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q.shift |-> hi_len_q == (n_eff >> 1));
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $stable(divisor_i) |=> cnt_q < n_eff);
endmodule

// File: rtl/spi_slave_recover.sv
module spi_slave_recover
  import spi_rate_pkg::*;
#(
  parameter int unsigned STAGES   = SYNC_STAGES,
  parameter int unsigned MIN_HALF = SLAVE_DIV / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_sck_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned GapW = $clog2(MIN_HALF + 2);
  localparam logic [GapW-1:0] GapMax = '1;

  logic [STAGES:0] sync_q;
  logic [GapW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], ext_sck_i};
  end

  // sync_q[STAGES-1] is the synchronized level, sync_q[STAGES] its previous value
  assign rise_o =  sync_q[STAGES-1] & ~sync_q[STAGES];
  assign fall_o = ~sync_q[STAGES-1] &  sync_q[STAGES];

  // checker state: cycles since last recovered edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= GapMax;
    else if (rise_o || fall_o) gap_q <= GapW'(1);
    else if (gap_q != GapMax)  gap_q <= gap_q + GapW'(1);
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> !(rise_o || fall_o));
  a_r8_min_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |-> gap_q >= GapW'(MIN_HALF));
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          slave_mode_i,
  input  logic [DW-1:0] divisor_i,
  input  logic          ext_sck_i,
  output logic          sck_o,
  output logic          sample_o,
  output logic          shift_o
);
  spi_tick_t m_tick;
  logic      s_rise, s_fall, m_run;

  assign m_run = en_i & ~slave_mode_i;

  spi_master_div #(.DW(DW), .MINV(MIN_DIV)) i_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (m_run),
    .divisor_i (divisor_i),
    .tick_o    (m_tick)
  );

  spi_slave_recover #(.STAGES(SYNC_STAGES), .MIN_HALF(SLAVE_DIV / 2)) i_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_sck_i (ext_sck_i),
    .rise_o    (s_rise),
    .fall_o    (s_fall)
  );

  assign sck_o    = m_tick.sck;
  assign sample_o = slave_mode_i ? (en_i & s_rise) : m_tick.sample;
  assign shift_o  = slave_mode_i ? (en_i & s_fall) : m_tick.shift;

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sck_o);
  a_r7_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode_i |=> !sck_o);
  a_r9_stop_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !slave_mode_i |=> !shift_o);
endmodule

// File: tb/test_spi_rate_gen.sv
module test_spi_rate_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        slave_mode_i = 1'b0;
  logic [11:0] divisor_i = 12'd0;
  logic        ext_sck_i = 1'b0;
  logic        sck_o, sample_o, shift_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {int period; int high;} exp_t;
  exp_t exp_q[$];

  always #4 clk_i = ~clk_i;

  spi_rate_gen i_spi_rate_gen (
    .clk_i, .rst_ni, .en_i, .slave_mode_i, .divisor_i, .ext_sck_i,
    .sck_o, .sample_o, .shift_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measures master clock periods and strobe alignment
  int  cyc = 0, last_rise = 0, hi_meas = 0;
  bit  have_rise = 0, prev_sck = 0;
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && !slave_mode_i) begin
      automatic bit rise = sck_o && !prev_sck;
      automatic bit fall = !sck_o && prev_sck;
      if (rise || sample_o) chk(rise == sample_o, "R4 sample vs rise", int'(sample_o), int'(rise));
      if (shift_o)          chk(fall, "R5 shift without fall", int'(fall), 1);
      if (fall && en_i)     chk(shift_o, "R5 fall without shift", int'(shift_o), 1);
      if (fall) hi_meas = cyc - last_rise;
      if (rise) begin
        if (have_rise && exp_q.size() > 0) begin
          automatic exp_t e = exp_q.pop_front();
          chk(cyc - last_rise == e.period, "R2 period", cyc - last_rise, e.period);
          chk(hi_meas == e.high, "R3 high time", hi_meas, e.high);
        end
        last_rise = cyc;
        have_rise = 1;
      end
      if (!en_i) have_rise = 0;
    end
    prev_sck = sck_o;
  end

  // driver: pushes expected periods then runs the generator
  task automatic run_master(input int div, input int k, input string tag);
    int n = (div < 2) ? 2 : div;
    for (int i = 0; i < k; i++) exp_q.push_back('{period: n, high: n / 2});
    @(negedge clk_i);
    divisor_i = 12'(div);
    en_i = 1'b1;
    repeat ((k + 1) * n + 2) @(negedge clk_i);
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    chk(sck_o == 1'b0, "R1 idle after disable", int'(sck_o), 0);
    exp_q.delete();
  endtask

  task automatic slave_edge(input logic val, input bit expect_pulse);
    ext_sck_i = val;
    @(negedge clk_i);
    chk(!sample_o && !shift_o, "R8 no pulse after one edge", int'(sample_o | shift_o), 0);
    @(negedge clk_i);
    if (expect_pulse) begin
      chk(sample_o == val && shift_o == !val, "R8 pulse after two edges",
          int'({sample_o, shift_o}), int'({val, !val}));
    end else begin
      chk(!sample_o && !shift_o, "R1 slave disabled no pulse", int'({sample_o, shift_o}), 0);
    end
    chk(sck_o == 1'b0, "R7 sck held low in slave", int'(sck_o), 0);
    @(negedge clk_i);
    chk(!sample_o && !shift_o, "R8 pulse one cycle", int'({sample_o, shift_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!sck_o && !sample_o && !shift_o, "R1 reset state", int'({sck_o, sample_o, shift_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!sck_o && !sample_o && !shift_o, "R1 disabled idle", int'({sck_o, sample_o, shift_o}), 0);

    run_master(9,    4, "R2 odd divisor 9");
    run_master(15,   4, "R2 odd divisor 15");
    run_master(22,   3, "R2 divisor 22");
    run_master(3,    5, "R3 divisor 3");
    run_master(2,    5, "R2 divisor 2");
    run_master(0,    5, "R6 divisor 0");
    run_master(1,    5, "R6 divisor 1");
    run_master(600,  2, "R2 divisor 600");
    run_master(4095, 2, "R2 full width divisor");

    // R9: stop while high
    @(negedge clk_i);
    divisor_i = 12'd10;
    en_i = 1'b1;
    while (!sck_o) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(!sck_o && !shift_o, "R9 stop while high", int'({sck_o, shift_o}), 0);
    repeat (3) @(negedge clk_i);

    // slave mode: divisor ignored, edges recovered
    slave_mode_i = 1'b1;
    divisor_i = 12'd5;
    repeat (4) @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
    slave_edge(1'b1, 1'b1);
    slave_edge(1'b0, 1'b1);
    divisor_i = 12'd9;
    slave_edge(1'b1, 1'b1);
    slave_edge(1'b0, 1'b1);
    en_i = 1'b0;
    slave_edge(1'b1, 1'b0);
    slave_edge(1'b0, 1'b0);
    repeat (3) @(negedge clk_i);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule